// File: doc/BRIEF.md
# Two-Dimensional Transfer Command Sequencer

This block turns one two-dimensional transfer request into two streams of command descriptors: read commands for the source side and write commands for the destination side. Each command carries a start address and a byte length. A request names a source base address, a destination base address, a per-array byte count, an array count, and a signed array stride for each side. The transfer is a set of equal-length arrays, one after another.

Each side keeps its own byte counter, array counter, reload copy of the byte count, and a saved start address of the array in progress. Commands are cut into pieces of at most `BURST` bytes that never cross the end of an array. When an array ends, the side reloads its byte counter and moves to the next array start, which is the saved start plus the side's stride. Neither stream waits for the other. A one-cycle completion pulse ends the request once both streams have issued their final command. Bus protocol, data storage and data movement belong to the blocks around it. It only hands out descriptors over valid/ready.

Top module: `xfer2d_seq`

## Requirements
- R1: After reset `req_ready` is 1, `rd_valid`, `wr_valid` and `done` are 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 1 exactly while idle. A request offered while busy is ignored and does not change the command streams.
- R3: Every command length equals the smaller of `BURST` and the bytes left in the current array, and it is never zero.
- R4: Within an array, each command address equals the previous command address of that side plus the previous length, modulo 2^32. The first array starts at the base address.
- R5: At the end of an array the byte counter reloads the requested byte count. The first command of the next array starts at the previous array start plus the side's 16-bit two's-complement stride, sign-extended to 32 bits, modulo 2^32.
- R6: A side issues exactly `req_bcnt` arrays of commands. Its array count drops only after the last command of an array is accepted, and the side raises no valid once the count reaches zero.
- R7: The two sides progress independently. Either side may finish all its commands while the other is held stalled by its ready.
- R8: `done` is 1 for exactly the cycle after the later of the two final command handshakes, and the block is idle (`req_ready` 1) in that same cycle.
- R9: A request with `req_acnt` 0 or `req_bcnt` 0 issues no command, the block stays idle, and `done` is 1 in the cycle after acceptance.
- R10: While a command is valid and not ready, its valid, address and length hold steady until the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_src | input | 32 | Source base address |
| req_dst | input | 32 | Destination base address |
| req_acnt | input | 16 | Bytes per array |
| req_bcnt | input | 16 | Number of arrays |
| req_sidx | input | 16 | Signed source array stride |
| req_didx | input | 16 | Signed destination array stride |
| rd_valid | output | 1 | Read command valid |
| rd_ready | input | 1 | Read command accepted |
| rd_addr | output | 32 | Read command address |
| rd_len | output | LEN_W | Read command byte length |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Write command accepted |
| wr_addr | output | 32 | Write command address |
| wr_len | output | LEN_W | Write command byte length |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the one where the two sides drift far apart: one side must finish all its arrays, with its counter reloads and stride jumps, while the other sits stalled mid-array. A plain ready pattern never gets there. The stimulus has modes that hold one side's ready low until the other side's expected queue is empty, and it runs those modes with negative strides and a byte count that is an exact multiple of the burst. Requests offered while busy are placed on long transfers, so the pending work outlasts the ignored offer.

// File: rtl/xfer2d_pkg.sv
package xfer2d_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 16;
  localparam int CNT_W  = 16;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [0:0] {ST_IDLE, ST_RUN} seq_state_e;

  // Bytes moved by one command: the burst cap, or less at the end of an array.
  function automatic cnt_t step_len(cnt_t remaining, cnt_t burst);
    return (remaining < burst) ? remaining : burst;
  endfunction

  // Start of the next array: saved start plus sign-extended stride.
  function automatic addr_t array_next(addr_t start, idx_t stride);
    return start + {{(ADDR_W-IDX_W){stride[IDX_W-1]}}, stride};
  endfunction

  function automatic logic req_is_empty(cnt_t acnt, cnt_t bcnt);
    return (acnt == '0) || (bcnt == '0);
  endfunction
endpackage

// File: rtl/xfer2d_side.sv
module xfer2d_side
  import xfer2d_pkg::*;
#(
  parameter int BURST = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  addr_t            ld_addr,
  input  cnt_t             ld_acnt,
  input  cnt_t             ld_bcnt,
  input  idx_t             ld_idx,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output addr_t            cmd_addr,
  output logic [LEN_W-1:0] cmd_len,
  output logic             empty,
  output logic             last_fire
);
  localparam cnt_t BURST_C = cnt_t'(BURST);

  addr_t addr_q, bref_q;
  cnt_t  acnt_q, rld_q, bcnt_q;
  idx_t  idx_q;

  cnt_t  len_full;
  addr_t next_start;
  logic  ev_fire, ev_array_end;

  assign len_full     = step_len(acnt_q, BURST_C);
  assign next_start   = array_next(bref_q, idx_q);
  assign cmd_valid    = (bcnt_q != '0);
  assign cmd_addr     = addr_q;
  assign cmd_len      = LEN_W'(len_full);
  assign empty        = (bcnt_q == '0);
  assign ev_fire      = cmd_valid && cmd_ready;
  assign ev_array_end = ev_fire && (len_full == acnt_q);
  assign last_fire    = ev_array_end && (bcnt_q == cnt_t'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bref_q <= '0;
      acnt_q <= '0;
      rld_q  <= '0;
      bcnt_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      addr_q <= ld_addr;
      bref_q <= ld_addr;
      acnt_q <= ld_acnt;
      rld_q  <= ld_acnt;
      bcnt_q <= ld_bcnt;
      idx_q  <= ld_idx;
    end else if (ev_fire) begin
      if (ev_array_end) begin
        acnt_q <= rld_q;
        bcnt_q <= bcnt_q - cnt_t'(1);
        bref_q <= next_start;
        addr_q <= next_start;
      end else begin
        acnt_q <= acnt_q - len_full;
        addr_q <= addr_q + addr_t'(len_full);
      end
    end
  end

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_len != '0) && (cmd_len <= LEN_W'(BURST)) && (cnt_t'(cmd_len) <= acnt_q)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !ev_array_end && !load) |=> (cmd_addr == $past(cmd_addr) + addr_t'($past(cmd_len)))); // R4

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_array_end && !last_fire && !load) |=> (acnt_q == rld_q) && cmd_valid && (cmd_addr == bref_q)); // R5

  AST_ARRAY_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_array_end && !load) |=> (bcnt_q == $past(bcnt_q) - cnt_t'(1))); // R6

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_array_end && !load) |=> $stable(bcnt_q)); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !load) |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)); // R10

  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty); // R2
endmodule

// File: rtl/xfer2d_ctrl.sv
module xfer2d_ctrl
  import xfer2d_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  cnt_t req_acnt,
  input  cnt_t req_bcnt,
  input  logic src_last,
  input  logic src_empty,
  input  logic dst_last,
  input  logic dst_empty,
  output logic req_ready,
  output logic load,
  output logic done
);
  seq_state_e state_q;
  logic ev_req_fire, ev_zero_req, ev_finish;

  assign req_ready   = (state_q == ST_IDLE);
  assign ev_req_fire = req_valid && req_ready;
  assign ev_zero_req = ev_req_fire && req_is_empty(req_acnt, req_bcnt);
  assign load        = ev_req_fire && !req_is_empty(req_acnt, req_bcnt);
  assign ev_finish   = (state_q == ST_RUN) &&
                       (src_last || src_empty) && (dst_last || dst_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= ev_zero_req || ev_finish;
      case (state_q)
        ST_IDLE: if (load) state_q <= ST_RUN;
        ST_RUN:  if (ev_finish) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R8

  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> done && req_ready); // R8

  AST_ZERO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero_req |=> done && req_ready && src_empty && dst_empty); // R9

  AST_RUN_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> !(src_empty && dst_empty)); // R6
endmodule

// File: rtl/xfer2d_seq.sv
module xfer2d_seq
  import xfer2d_pkg::*;
#(
  parameter int BURST = 64,
  localparam int LEN_W = $clog2(BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_src,
  input  logic [31:0]      req_dst,
  input  logic [15:0]      req_acnt,
  input  logic [15:0]      req_bcnt,
  input  logic [15:0]      req_sidx,
  input  logic [15:0]      req_didx,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [31:0]      rd_addr,
  output logic [LEN_W-1:0] rd_len,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [31:0]      wr_addr,
  output logic [LEN_W-1:0] wr_len,
  output logic             done
);
  logic load;
  logic src_last, src_empty, dst_last, dst_empty;

  xfer2d_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_acnt  (req_acnt),
    .req_bcnt  (req_bcnt),
    .src_last  (src_last),
    .src_empty (src_empty),
    .dst_last  (dst_last),
    .dst_empty (dst_empty),
    .req_ready (req_ready),
    .load      (load),
    .done      (done)
  );

  xfer2d_side #(.BURST(BURST), .LEN_W(LEN_W)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_addr   (req_src),
    .ld_acnt   (req_acnt),
    .ld_bcnt   (req_bcnt),
    .ld_idx    (req_sidx),
    .cmd_valid (rd_valid),
    .cmd_ready (rd_ready),
    .cmd_addr  (rd_addr),
    .cmd_len   (rd_len),
    .empty     (src_empty),
    .last_fire (src_last)
  );

  xfer2d_side #(.BURST(BURST), .LEN_W(LEN_W)) u_dst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_addr   (req_dst),
    .ld_acnt   (req_acnt),
    .ld_bcnt   (req_bcnt),
    .ld_idx    (req_didx),
    .cmd_valid (wr_valid),
    .cmd_ready (wr_ready),
    .cmd_addr  (wr_addr),
    .cmd_len   (wr_len),
    .empty     (dst_empty),
    .last_fire (dst_last)
  );

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && (rd_valid || wr_valid)) |=> !done || (rd_valid == 1'b0 && wr_valid == 1'b0)); // R2
endmodule

// File: tb/xfer2d_seq_test.sv
module xfer2d_seq_test;
  localparam int BURST = 64;
  localparam int LEN_W = $clog2(BURST + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_src = '0, req_dst = '0;
  logic [15:0] req_acnt = '0, req_bcnt = '0, req_sidx = '0, req_didx = '0;
  logic rd_ready = 1'b0, wr_ready = 1'b0;
  logic req_ready, rd_valid, wr_valid, done;
  logic [31:0] rd_addr, wr_addr;
  logic [LEN_W-1:0] rd_len, wr_len;

  always #2.5 clk = ~clk;

  xfer2d_seq #(.BURST(BURST)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_acnt(req_acnt), .req_bcnt(req_bcnt),
    .req_sidx(req_sidx), .req_didx(req_didx),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
    .done(done)
  );

  typedef struct { logic [31:0] a; int l; bit new_arr; } cmd_t;
  cmd_t rq[$];
  cmd_t wq[$];
  int  n_cmp = 0, n_bad = 0;
  bit  m_busy = 0, exp_done = 0, exp_zero = 0;
  bit  rd_stall = 0, wr_stall = 0;
  int  mode = 0;

  task automatic chk(string tag, longint act, longint exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic build(ref cmd_t q[$], input logic [31:0] base, input int acnt,
                       input int bcnt, input logic [15:0] idx);
    logic [31:0] start = base;
    for (int b = 0; b < bcnt; b++) begin
      logic [31:0] a = start;
      int rem = acnt;
      bit first = (b != 0);
      while (rem > 0) begin
        cmd_t c;
        int l = (rem > BURST) ? BURST : rem;
        c.a = a; c.l = l; c.new_arr = first;
        q.push_back(c);
        a = a + 32'(l);
        rem = rem - l;
        first = 0;
      end
      start = start + 32'($signed(idx));
    end
  endtask

  // Reference model, compared on every falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit dn;
      string vt;
      vt = (mode >= 2) ? "R7" : "R6";
      chk("R2", req_ready, !m_busy, "req_ready");
      chk(exp_zero ? "R9" : "R8", done, exp_done, "done");
      chk(vt, rd_valid, rq.size() != 0, "rd_valid");
      chk(vt, wr_valid, wq.size() != 0, "wr_valid");
      if (rd_valid && rq.size() != 0) begin
        chk(rd_stall ? "R10" : (rq[0].new_arr ? "R5" : "R4"), rd_addr, rq[0].a, "rd_addr");
        chk(rd_stall ? "R10" : "R3", rd_len, rq[0].l, "rd_len");
      end
      if (wr_valid && wq.size() != 0) begin
        chk(wr_stall ? "R10" : (wq[0].new_arr ? "R5" : "R4"), wr_addr, wq[0].a, "wr_addr");
        chk(wr_stall ? "R10" : "R3", wr_len, wq[0].l, "wr_len");
      end
      rd_stall = rd_valid && !rd_ready;
      wr_stall = wr_valid && !wr_ready;
      dn = 0;
      exp_zero = 0;
      if (req_valid && !m_busy) begin
        if (req_acnt == 0 || req_bcnt == 0) begin
          dn = 1; exp_zero = 1;
        end else begin
          build(rq, req_src, int'(req_acnt), int'(req_bcnt), req_sidx);
          build(wq, req_dst, int'(req_acnt), int'(req_bcnt), req_didx);
          m_busy = 1;
        end
      end else if (m_busy) begin
        if (rd_valid && rd_ready && rq.size() != 0) void'(rq.pop_front());
        if (wr_valid && wr_ready && wq.size() != 0) void'(wq.pop_front());
        if (rq.size() == 0 && wq.size() == 0) begin
          dn = 1; m_busy = 0;
        end
      end
      exp_done = dn;
    end
  end

  // Ready patterns: 0 always, 1 random, 2 writes wait for reads, 3 reads wait for writes.
  initial begin
    forever begin
      @(posedge clk); #1;
      case (mode)
        0: begin rd_ready = 1; wr_ready = 1; end
        1: begin rd_ready = ($urandom % 3) != 0; wr_ready = ($urandom % 2) != 0; end
        2: begin rd_ready = 1; wr_ready = (rq.size() == 0); end
        default: begin wr_ready = 1; rd_ready = (wq.size() == 0); end
      endcase
    end
  end

  task automatic run_req(input logic [31:0] s, input logic [31:0] d, input int ac,
                         input int bc, input logic [15:0] si, input logic [15:0] di,
                         input int md, input bit junk);
    @(posedge clk); #1;
    mode = md;
    req_src = s; req_dst = d; req_acnt = 16'(ac); req_bcnt = 16'(bc);
    req_sidx = si; req_didx = di; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    if (junk) begin
      // R2: offer a different request while busy; it must be ignored
      repeat (2) @(posedge clk); #1;
      req_src = 32'hDEAD_0000; req_acnt = 16'd5; req_bcnt = 16'd1; req_valid = 1;
      repeat (2) @(posedge clk); #1;
      req_valid = 0;
    end
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    mode = 0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R1", req_ready, 1, "req_ready in reset");
    chk("R1", rd_valid, 0, "rd_valid in reset");
    chk("R1", wr_valid, 0, "wr_valid in reset");
    chk("R1", done, 0, "done in reset");
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", req_ready, 1, "req_ready after reset");
    run_req(32'h1000, 32'h8000, 10, 3, 16'd100, 16'hFFCE, 0, 0);
    run_req(32'h2_0000, 32'h4_0000, 200, 4, 16'h8000, 16'd300, 1, 1);
    run_req(32'h3000, 32'h9000, 64, 3, 16'hFF00, 16'd64, 2, 0);
    run_req(32'h5000, 32'hA000, 130, 3, 16'd256, 16'hFFFE, 3, 1);
    run_req(32'h6000, 32'hB000, 0, 5, 16'd1, 16'd1, 0, 0);
    run_req(32'h6000, 32'hB000, 7, 0, 16'd1, 16'd1, 0, 0);
    run_req(32'h7000, 32'hC000, 1, 1, 16'd0, 16'd0, 0, 0);
    run_req(32'hFFFF_FFF0, 32'hFFFF_FF00, 40, 3, 16'd16, 16'hFFF0, 1, 0);
    run_req(32'h100, 32'h200, 65, 2, 16'd0, 16'd0, 2, 0);
    for (int i = 0; i < 6; i++)
      run_req($urandom, $urandom, 1 + ($urandom % 300), 1 + ($urandom % 5),
              16'($urandom), 16'($urandom), 1 + (i % 3), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R8 watchdog: actual hung expected done at %0t", $time);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule